// File: doc/BRIEF.md
# SDRAM Single-Burst Command Sequencer

This block drives the command pins of an SDRAM for exactly one access: it opens a row, issues one column read or write burst, and closes the row again. A requester offers an access on a valid/ready handshake, together with a set of timing fields. The fields are captured when the access is accepted and stay fixed for the whole sequence. They give the burst length, the CAS latency, where the precharge falls relative to the last read beat, the write recovery time, the activate-to-column delay, and two modes for slow boards. One mode adds an extra address-mux cycle ahead of the row command. The other holds every command line except chip select for two cycles.

Besides the command lines, the block produces an address-mux select, a data-valid strobe that marks each beat of the burst, and a one-cycle completion pulse. A request is accepted at a rising clock edge where `req_valid` and `req_ready` are both high. `req_valid` may be held high for as long as the requester likes. `req_ready` is low while a sequence runs and also while the offered fields hold a reserved code, so an invalid request is never consumed. Refresh, mode programming, keeping rows open across accesses and the data path itself are left to neighbouring logic.

Top module: `sdram_cmd_seq`

Timing below is counted in cycles k = 0, 1, 2, … after the accepting edge. Cycle 0 is the first cycle of the sequence. Let s = `cfg_cmd_buf`, x = `cfg_amux_en`, d = `cfg_act_dly`, B = the burst length, and L = the cycle of the last data beat.

## Requirements
- R1: `cfg_burst8`=0 gives exactly 4 data beats and `cfg_burst8`=1 gives exactly 8. The beats fall on consecutive cycles, and `data_valid` is high for each of them.
- R2: For a read, the first beat comes `cfg_cas_lat` cycles after the cycle in which READ is issued. The codes are 01→1, 10→2 and 11→3.
- R3: For a read, PRECHARGE is issued at L−`cfg_rd_pre`. The codes are 00→0, 01→1 cycle early and 10→2 cycles early.
- R4: For a write, the first beat falls in the cycle in which WRITE is issued. PRECHARGE is issued at L plus the recovery time, where `cfg_wr_rec` 01→1, 10→2, 11→3 and 00→4.
- R5: ACTIVATE is issued in cycle a = x+s. READ or WRITE is issued in cycle a+d+s, where `cfg_act_dly` 01, 10 and 11 give d = 1, 2 and 3.
- R6: `amux_sel` is high in cycles 0..a of a sequence and low otherwise. With x=1 this adds one cycle before the ACTIVATE command.
- R7: With s=1, the RAS/CAS/WE pattern of each command is already driven in the cycle before its issue cycle while chip select stays high. Chip select goes low only in the issue cycle.
- R8: The command lines {cs_n,ras_n,cas_n,we_n} carry ACTIVATE=0011, READ=0101, WRITE=0100 and PRECHARGE=0010 in their issue cycles. In every cycle with no command they carry 1111, including while idle after reset.
- R9: `req_ready` is low from cycle 0 up to and including cycle max(P+1, L), where P is the precharge issue cycle. It returns high in the cycle after that, and no second request is accepted while it is low.
- R10: `done` is high for exactly one cycle, P+1, which is the cycle after PRECHARGE.
- R11: `cfg_err` is high, `req_ready` is low and no command is issued while the offered fields hold a reserved code. The reserved codes are `cfg_cas_lat`=00, `cfg_rd_pre`=11, `cfg_act_dly`=00, and `cfg_amux_en`=1 together with `cfg_act_dly`=01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| cfg_burst8 | input | 1 | Burst length select: 0 = 4 beats, 1 = 8 beats |
| cfg_cas_lat | input | 2 | CAS latency code |
| cfg_rd_pre | input | 2 | Precharge advance before the last read beat |
| cfg_wr_rec | input | 2 | Write recovery code |
| cfg_amux_en | input | 1 | Extra address-mux cycle before ACTIVATE |
| cfg_cmd_buf | input | 1 | Two-cycle command lines (buffered board) |
| cfg_act_dly | input | 2 | Activate-to-read/write delay code |
| cfg_err | output | 1 | Offered fields hold a reserved code |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM RAS, active low |
| sd_cas_n | output | 1 | SDRAM CAS, active low |
| sd_we_n | output | 1 | SDRAM WE, active low |
| amux_sel | output | 1 | Row-address mux select |
| data_valid | output | 1 | Data beat strobe |
| done | output | 1 | One-cycle pulse after PRECHARGE |

## Verification
The bench builds the block with its default timeline counter width of 6 bits. That width covers the longest schedule, a write with all stretching modes, delay 3, 8 beats and 4 recovery cycles, which ends by cycle 18. This lets random field combinations reach the longest schedule without wrapping. Directed cases hit the earliest read precharge, where PRECHARGE lands before the final beat and `done` arrives while beats are still flowing. They also hit the shortest command spacing, where READ follows ACTIVATE in the next cycle, and every reserved code.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command line pattern, ordered {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_IDLE  = 4'b1111,
    CMD_ACT   = 4'b0011,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100,
    CMD_PRE   = 4'b0010
  } sd_cmd_e;

  // Fields captured at request acceptance
  typedef struct packed {
    logic       wr;
    logic       burst8;
    logic [1:0] cas_lat;
    logic [1:0] rd_pre;
    logic [1:0] wr_rec;
    logic       amux_en;
    logic       cmd_buf;
    logic [1:0] act_dly;
  } seq_cfg_t;

  // Recovery code to cycles: 00 means four
  function automatic logic [2:0] rec_cycles(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction

endpackage

// File: rtl/seq_cfg_check.sv
module seq_cfg_check (
  input  logic [1:0] cas_lat,
  input  logic [1:0] rd_pre,
  input  logic       amux_en,
  input  logic [1:0] act_dly,
  output logic       bad
);
  logic cl_bad, pre_bad, dly_bad, mux_bad;

  always_comb begin
    cl_bad  = (cas_lat == 2'b00);
    pre_bad = (rd_pre == 2'b11);
    dly_bad = (act_dly == 2'b00);
    // the extra mux cycle needs at least two cycles before the column command
    mux_bad = amux_en && (act_dly == 2'b01);
    bad     = cl_bad | pre_bad | dly_bad | mux_bad;
  end
endmodule

// File: rtl/seq_timing.sv
module seq_timing
  import sdram_seq_pkg::*;
#(
  parameter int CW = 6
) (
  input  seq_cfg_t        cfg,
  output logic [CW-1:0]   t_act,
  output logic [CW-1:0]   t_col,
  output logic [CW-1:0]   t_first,
  output logic [CW-1:0]   t_last,
  output logic [CW-1:0]   t_pre,
  output logic [CW-1:0]   t_end
);
  logic [CW-1:0] span, pre_done;

  always_comb begin
    span     = cfg.burst8 ? CW'(7) : CW'(3);
    t_act    = CW'(cfg.amux_en) + CW'(cfg.cmd_buf);
    t_col    = t_act + CW'(cfg.act_dly) + CW'(cfg.cmd_buf);
    t_first  = cfg.wr ? t_col : t_col + CW'(cfg.cas_lat);
    t_last   = t_first + span;
    t_pre    = cfg.wr ? t_last + CW'(rec_cycles(cfg.wr_rec))
                      : t_last - CW'(cfg.rd_pre);
    pre_done = t_pre + CW'(1);
    t_end    = (pre_done > t_last) ? pre_done : t_last;
  end
endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] t_end,
  output logic          busy,
  output logic [CW-1:0] tcnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      tcnt <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tcnt <= '0;
    end else if (busy) begin
      if (tcnt == t_end) begin
        busy <= 1'b0;
        tcnt <= '0;
      end else begin
        tcnt <= tcnt + CW'(1);
      end
    end
  end

  // R9: the timeline never runs past its final cycle
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tcnt <= t_end));
endmodule

// File: rtl/seq_cmd_out.sv
module seq_cmd_out
  import sdram_seq_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic [CW-1:0] tcnt,
  input  logic          stretch,
  input  logic          wr,
  input  logic [CW-1:0] t_act,
  input  logic [CW-1:0] t_col,
  input  logic [CW-1:0] t_pre,
  output logic [3:0]    cmd
);
  localparam int NCMD = 3;

  logic [CW-1:0] issue [NCMD];
  logic [3:0]    pat   [NCMD];
  logic [NCMD-1:0] hold, fire;

  always_comb begin
    issue[0] = t_act;  pat[0] = CMD_ACT;
    issue[1] = t_col;  pat[1] = wr ? CMD_WRITE : CMD_READ;
    issue[2] = t_pre;  pat[2] = CMD_PRE;
  end

  for (genvar i = 0; i < NCMD; i++) begin : g_win
    assign fire[i] = busy && (tcnt == issue[i]);
    assign hold[i] = fire[i] || (busy && stretch && (tcnt + CW'(1) == issue[i]));
  end

  always_comb begin
    cmd = CMD_IDLE;
    for (int i = 0; i < NCMD; i++) begin
      if (hold[i]) cmd = {~fire[i], pat[i][2:0]};
    end
  end

  // R8: command windows never overlap
  p_one_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hold));

  // R7: in stretched mode the strobe pattern was already present a cycle earlier
  p_stretch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stretch && busy && !cmd[3]) |-> ($past(cmd[2:0]) == cmd[2:0] && $past(cmd[3])));
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       cfg_burst8,
  input  logic [1:0] cfg_cas_lat,
  input  logic [1:0] cfg_rd_pre,
  input  logic [1:0] cfg_wr_rec,
  input  logic       cfg_amux_en,
  input  logic       cfg_cmd_buf,
  input  logic [1:0] cfg_act_dly,
  output logic       cfg_err,
  output logic       sd_cs_n,
  output logic       sd_ras_n,
  output logic       sd_cas_n,
  output logic       sd_we_n,
  output logic       amux_sel,
  output logic       data_valid,
  output logic       done
);
  seq_cfg_t      cfg_q;
  logic          busy, accept;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] t_act, t_col, t_first, t_last, t_pre, t_end;
  logic [3:0]    cmd;

  seq_cfg_check u_check (
    .cas_lat (cfg_cas_lat),
    .rd_pre  (cfg_rd_pre),
    .amux_en (cfg_amux_en),
    .act_dly (cfg_act_dly),
    .bad     (cfg_err)
  );

  assign req_ready = !busy && !cfg_err;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (accept) begin
      cfg_q <= '{wr: req_write, burst8: cfg_burst8, cas_lat: cfg_cas_lat,
                 rd_pre: cfg_rd_pre, wr_rec: cfg_wr_rec, amux_en: cfg_amux_en,
                 cmd_buf: cfg_cmd_buf, act_dly: cfg_act_dly};
    end
  end

  seq_timing #(.CW(CW)) u_timing (
    .cfg     (cfg_q),
    .t_act   (t_act),
    .t_col   (t_col),
    .t_first (t_first),
    .t_last  (t_last),
    .t_pre   (t_pre),
    .t_end   (t_end)
  );

  seq_counter #(.CW(CW)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .t_end (t_end),
    .busy  (busy),
    .tcnt  (tcnt)
  );

  seq_cmd_out #(.CW(CW)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .tcnt    (tcnt),
    .stretch (cfg_q.cmd_buf),
    .wr      (cfg_q.wr),
    .t_act   (t_act),
    .t_col   (t_col),
    .t_pre   (t_pre),
    .cmd     (cmd)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign amux_sel   = busy && (tcnt <= t_act);
  assign data_valid = busy && (tcnt >= t_first) && (tcnt <= t_last);
  assign done       = busy && (tcnt == t_pre + CW'(1));

  // R10: completion follows the PRECHARGE issue cycle
  p_done_after_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cmd) == CMD_PRE));

  // R6: the mux select drops right after ACTIVATE
  p_amux_act_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(amux_sel) |-> ($past(cmd) == CMD_ACT));

  // R11: a reserved request leaves the sequencer idle
  p_err_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && cfg_err) |=> (cmd == CMD_IDLE));

  // R9: beats only flow while the handshake is closed
  p_beats_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> !req_ready);
endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  localparam int HALF = 10;  // 50 MHz

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, cfg_burst8 = 1'b0;
  logic [1:0] cfg_cas_lat = 2'd1, cfg_rd_pre = 2'd0, cfg_wr_rec = 2'd1, cfg_act_dly = 2'd1;
  logic cfg_amux_en = 1'b0, cfg_cmd_buf = 1'b0;
  logic req_ready, cfg_err, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, amux_sel, data_valid, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #HALF clk = ~clk;

  sdram_cmd_seq dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int cmd_pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  // one access, every cycle of its timeline compared with the requirement model
  task automatic run_seq(input bit wr, input bit b8, input int cl, input int rp,
                         input int wrc, input bit mx, input bit sb, input int dl);
    int a, col, first, last, pre, fin, nb, rec, ecmd, pat;
    string ctag;
    @(negedge clk);
    req_write = wr; cfg_burst8 = b8; cfg_cas_lat = 2'(cl); cfg_rd_pre = 2'(rp);
    cfg_wr_rec = 2'(wrc); cfg_amux_en = mx; cfg_cmd_buf = sb; cfg_act_dly = 2'(dl);
    req_valid = 1'b1;
    chk("R9 ready before", int'(req_ready), 1);
    rec   = (wrc == 0) ? 4 : wrc;
    a     = int'(mx) + int'(sb);                 // R5
    col   = a + dl + int'(sb);                   // R5
    first = wr ? col : col + cl;                 // R2 / R4
    last  = first + (b8 ? 7 : 3);                // R1
    pre   = wr ? last + rec : last - rp;         // R3 / R4
    fin   = (pre + 1 > last) ? pre + 1 : last;   // R9
    nb = 0;
    for (int j = 0; j <= fin + 1; j++) begin
      @(negedge clk);
      req_valid = (j < 2);                       // held valid must not start a second access
      ecmd = 4'hF; ctag = sb ? "R7" : "R8";
      foreach (pat[k]) ;
      if (j == a || (sb && j == a - 1)) ecmd = {j != a, 3'b011};
      if (j == col || (sb && j == col - 1)) begin
        ecmd = {j != col, wr ? 3'b100 : 3'b101}; ctag = "R5";
      end
      if (j == pre || (sb && j == pre - 1)) begin
        ecmd = {j != pre, 3'b010}; ctag = wr ? "R4" : "R3";
      end
      if (j > fin) begin ecmd = 4'hF; ctag = "R8"; end
      chk(ctag, cmd_pins(), ecmd);
      chk("R6", int'(amux_sel), int'(j <= a));
      chk(wr ? "R4" : "R2", int'(data_valid), int'(j >= first && j <= last));
      chk("R10", int'(done), int'(j == pre + 1));
      chk("R9", int'(req_ready), int'(j > fin));
      nb += int'(data_valid);
    end
    chk("R1 beat count", nb, b8 ? 8 : 4);
    req_valid = 1'b0;
  endtask

  task automatic bad_req(input int cl, input int rp, input bit mx, input int dl);
    @(negedge clk);
    cfg_cas_lat = 2'(cl); cfg_rd_pre = 2'(rp); cfg_amux_en = mx; cfg_act_dly = 2'(dl);
    req_valid = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R11 err", int'(cfg_err), 1);
      chk("R11 ready", int'(req_ready), 0);
      chk("R11 idle", cmd_pins(), 4'hF);
      chk("R11 beats", int'(data_valid), 0);
    end
    req_valid = 1'b0;
    cfg_cas_lat = 2'd1; cfg_rd_pre = 2'd0; cfg_amux_en = 1'b0; cfg_act_dly = 2'd1;
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset cmd", cmd_pins(), 4'hF);
    chk("R9 reset ready", int'(req_ready), 1);
    chk("R10 reset done", int'(done), 0);
    chk("R6 reset amux", int'(amux_sel), 0);

    // directed corners
    run_seq(0, 0, 1, 2, 1, 0, 0, 1);   // R3 earliest precharge, R5 minimum spacing
    run_seq(0, 1, 3, 0, 1, 1, 1, 3);   // R6 R7 longest read
    run_seq(1, 1, 1, 0, 0, 1, 1, 3);   // R4 recovery 4, longest write
    run_seq(1, 0, 2, 0, 1, 0, 1, 1);   // R7 stretched short write
    run_seq(0, 0, 2, 1, 2, 1, 0, 2);   // R6 extra mux cycle
    bad_req(0, 0, 0, 1);               // R11 reserved CAS latency
    bad_req(1, 3, 0, 1);               // R11 reserved precharge offset
    bad_req(1, 0, 0, 0);               // R11 reserved delay
    bad_req(1, 0, 1, 1);               // R11 mux with delay 1

    for (int n = 0; n < 60; n++) begin
      bit mx;
      int dl;
      mx = 1'($urandom_range(0, 1));
      dl = mx ? int'($urandom_range(2, 3)) : int'($urandom_range(1, 3));
      run_seq(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              int'($urandom_range(1, 3)), int'($urandom_range(0, 2)),
              int'($urandom_range(0, 3)), mx, 1'($urandom_range(0, 1)), dl);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(2 * HALF * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule